// File: doc/BRIEF.md
# Programmable Word-Offset Clock Divider

This block derives a slower clock from an input clock. A 7-bit divide word sets the ratio. The output period, in input cycles, is the word plus a fixed offset of two, so ratios from 3 to 129 can be reached. Every output period ends with a low phase of exactly two input cycles. The high phase fills the rest of the period, so the duty cycle rises with the ratio. A ratio of 20, for example, gives 18 high cycles out of 20.

The word is meant to be static, strapped at integration time. Any word bit that is left unconnected must be tied to 1, so an untouched word reads as all ones and selects the slowest ratio of 129. The word may still change during operation. A change is picked up only when an output period ends, so no period is ever cut short. A word of zero is not a legal setting. The block divides by 3 in that case, as if the word were 1, and it raises a flag that stays set until the next reset. The output comes straight from a flip-flop, so it has no glitches.

Top module: `wofs_clk_div`

## Requirements
- R1: While reset is asserted (sampled low at a clock edge), the divided clock is high and the illegal-word flag is low. The word present during reset sets the first period: with a ratio R, the first low output is seen R-2 input edges after the first edge at which reset is sampled high.
- R2: For a legal word W (1 to 127), each output period, measured from one rising edge of the divided clock to the next, lasts W+2 input cycles.
- R3: In every output period the divided clock is low for exactly 2 input cycles. It is high for the other W cycles.
- R4: The extremes of the range: word 1 gives a period of 3 cycles, and the all-ones word 127 gives 129 cycles.
- R5: A word of 0 is divided as if it were 1, giving a period of 3 cycles with 2 low.
- R6: The illegal-word flag rises on the input edge that ends an output period while the word reads 0, which is the same edge on which the divided clock rises. It stays low while only legal words are applied.
- R7: Once set, the illegal-word flag stays high whatever word is applied later, until reset clears it.
- R8: A word change becomes effective only at the end of an output period. The period in progress completes with the old ratio, and the next full period uses the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Synchronous reset, active low |
| word_i | input | 7 | Divide word; ratio = word + 2; unconnected bits tied to 1 |
| div_clk_o | output | 1 | Divided clock, registered, low for 2 input cycles per period |
| illegal_o | output | 1 | Sticky flag: a zero word was taken at a period end |

## Verification
A counter that is off by even one shows up at the ports within a single output period: a period one cycle too long or too short, or a low phase of one or three cycles. That is at most 129 input cycles after the fault. A word taken at the wrong moment shows as a truncated or stretched period right after a change, so the bench changes the word just after a rising output edge. It then times that period and the next one separately. A flag that is not sticky, or that is set when it should not be, is visible by the next period boundary. The flag is therefore read both after a zero word and after the following legal periods.

// File: rtl/wdiv_pkg.sv
// Package: shared default settings for the word-offset clock divider.
// Assumes: users override these only through the top-level parameters.
package wdiv_pkg;
    localparam int unsigned DEF_WORD_W  = 7; // width of the divide word
    localparam int unsigned DEF_OFFSET  = 2; // ratio = word + offset
    localparam int unsigned DEF_LOW_LEN = 2; // low cycles per output period
endpackage

// File: rtl/wdiv_word_guard.sv
// Module: wdiv_word_guard
// Maps an illegal zero word onto the smallest legal word. It also keeps a
// sticky flag that records a zero word taken at a period end.
// Assumes: sample_i pulses on the cycle whose edge reloads the counter.
module wdiv_word_guard #(
    parameter int unsigned WORD_W = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] word_i,
    input  logic              sample_i,
    output logic [WORD_W-1:0] word_eff_o,
    output logic              illegal_o
);
    logic is_zero;
    logic flag_q;

    // Substitute word 1 for the illegal zero word.
    always_comb begin
        is_zero    = (word_i == '0);
        word_eff_o = is_zero ? WORD_W'(1) : word_i;
    end

    // Sticky flag: set when a zero word is taken, cleared only by reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (sample_i && is_zero) begin
            flag_q <= 1'b1;
        end
    end

    assign illegal_o = flag_q;
endmodule

// File: rtl/wdiv_period_ctr.sv
// Module: wdiv_period_ctr
// Down-counter that spans one output period. It loads ratio-1 and counts to
// zero. The next word is taken only when the count is zero, so a period is
// never truncated.
// Assumes: word_eff_i is nonzero. CNT_W holds 2^WORD_W - 1 + OFFSET - 1.
module wdiv_period_ctr #(
    parameter int unsigned WORD_W = 7,
    parameter int unsigned OFFSET = 2,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] word_eff_i,
    output logic [CNT_W-1:0]  cnt_nxt_o,
    output logic              wrap_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    // Reload value and next count: reload at zero, otherwise count down.
    always_comb begin
        reload    = CNT_W'(word_eff_i) + CNT_W'(OFFSET - 1);
        wrap_o    = (cnt_q == '0);
        cnt_nxt_o = wrap_o ? reload : (cnt_q - CNT_W'(1));
    end

    // Count register: reset loads the current word's period.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_nxt_o;
        end
    end
endmodule

// File: rtl/wdiv_out_reg.sv
// Module: wdiv_out_reg
// Registered divided-clock output. It is low while the count register holds
// a value below LOW_LEN, that is for LOW_LEN cycles per period. It decodes
// the next count, so the output and the count register change together.
// Assumes: LOW_LEN is below the smallest ratio.
module wdiv_out_reg #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned LOW_LEN = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    output logic             div_clk_o
);
    logic out_q;

    // Output flip-flop: high in reset, low for the last LOW_LEN counts.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= 1'b1;
        end else begin
            out_q <= (cnt_nxt_i >= CNT_W'(LOW_LEN));
        end
    end

    assign div_clk_o = out_q;
endmodule

// File: rtl/wofs_clk_div.sv
// Module: wofs_clk_div
// Top of the word-offset clock divider: ratio = word + OFFSET, with a fixed
// LOW_LEN-cycle low phase at the end of each output period.
// Assumes: word_i is static or changes rarely, and unconnected bits are tied
// to 1 at integration.
module wofs_clk_div #(
    parameter int unsigned WORD_W  = wdiv_pkg::DEF_WORD_W,
    parameter int unsigned OFFSET  = wdiv_pkg::DEF_OFFSET,
    parameter int unsigned LOW_LEN = wdiv_pkg::DEF_LOW_LEN
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] word_i,
    output logic              div_clk_o,
    output logic              illegal_o
);
    localparam int unsigned MAX_RATIO = (1 << WORD_W) - 1 + OFFSET;
    localparam int unsigned CNT_W     = $clog2(MAX_RATIO);

    logic [WORD_W-1:0] word_eff;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              wrap;

    wdiv_word_guard #(
        .WORD_W (WORD_W)
    ) guard_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .word_i     (word_i),
        .sample_i   (wrap),
        .word_eff_o (word_eff),
        .illegal_o  (illegal_o)
    );

    wdiv_period_ctr #(
        .WORD_W (WORD_W),
        .OFFSET (OFFSET),
        .CNT_W  (CNT_W)
    ) ctr_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .word_eff_i (word_eff),
        .cnt_nxt_o  (cnt_nxt),
        .wrap_o     (wrap)
    );

    wdiv_out_reg #(
        .CNT_W   (CNT_W),
        .LOW_LEN (LOW_LEN)
    ) out_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cnt_nxt_i (cnt_nxt),
        .div_clk_o (div_clk_o)
    );
endmodule

// File: rtl/wdiv_chk.sv
// Module: wdiv_chk
// Assertion checker for wofs_clk_div, attached with bind below.
// Assumes: the low phase is two cycles long (default LOW_LEN).
module wdiv_chk #(
    parameter int unsigned MAX_RATIO = 129
) (
    input logic clk_i,
    input logic rst_ni,
    input logic div_clk_o,
    input logic illegal_o
);
    logic        was_rst = 1'b0;
    logic        prev_out = 1'b1;
    logic [15:0] since_rise = '0;

    // Track the previous reset level, the previous output and the cycles since the last rising output edge.
    always_ff @(posedge clk_i) begin
        was_rst  <= !rst_ni;
        prev_out <= div_clk_o;
        if (!rst_ni) begin
            since_rise <= '0;
        end else if (div_clk_o && !prev_out) begin
            since_rise <= 16'd1;
        end else if (since_rise != 16'hFFFF) begin
            since_rise <= since_rise + 16'd1;
        end
    end

    // R1
    reset_hold_chk: assert property (@(posedge clk_i)
        was_rst |-> (div_clk_o && !illegal_o));

    // R3
    low_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(div_clk_o) |=> !div_clk_o);

    // R3
    low_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!div_clk_o && !$past(div_clk_o)) |=> div_clk_o);

    // R6
    flag_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(illegal_o) |-> $rose(div_clk_o));

    // R7
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |=> illegal_o);

    // R2
    period_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        since_rise <= 16'(MAX_RATIO));
endmodule

bind wofs_clk_div wdiv_chk #(
    .MAX_RATIO (MAX_RATIO)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_clk_o (div_clk_o),
    .illegal_o (illegal_o)
);

// File: tb/wofs_clk_div_tb_top.sv
`timescale 1ns/1ps
module wofs_clk_div_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] word = 7'd127;
    logic       div_clk;
    logic       illegal;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    wofs_clk_div dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .word_i    (word),
        .div_clk_o (div_clk),
        .illegal_o (illegal)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance to the first sample where the output has just risen.
    task automatic wait_rise();
        logic prev = div_clk;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (!prev && div_clk) return;
            prev = div_clk;
        end
    endtask

    // From a rise sample, count high and low cycles up to the next rise sample.
    task automatic measure(output int hi, output int lo);
        hi = 1;
        lo = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (div_clk) hi++; else break;
        end
        lo = 1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (!div_clk) lo++; else break;
        end
    endtask

    // R1: reset state and the first period after reset release.
    task automatic t_reset(input logic [6:0] w);
        int n = 0;
        word  = w;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "output high in reset", int'(div_clk), 1);
        chk("R1", "flag low in reset", int'(illegal), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            n++;
            if (!div_clk) break;
        end
        chk("R1", "edges to first low", n, int'(w) + 2 - 2);
    endtask

    // R2/R3: a legal word gives period word+2 with a low phase of 2.
    task automatic t_ratio(input string req, input logic [6:0] w);
        int hi, lo;
        word = w;
        wait_rise();
        measure(hi, lo);
        chk(req, "period", hi + lo, int'(w) + 2);
        chk("R3", "low cycles", lo, 2);
        chk("R3", "high cycles", hi, int'(w));
    endtask

    // R8: a change right after a rise leaves the current period alone.
    task automatic t_change();
        int hi, lo;
        word = 7'd18;
        wait_rise();
        measure(hi, lo);
        word = 7'd40;
        measure(hi, lo);
        chk("R8", "period after change", hi + lo, 20);
        measure(hi, lo);
        chk("R8", "next period", hi + lo, 42);
        chk("R6", "no flag for legal words", int'(illegal), 0);
    endtask

    // R5/R6/R7: zero word divides by 3, sets the flag, and the flag is sticky.
    task automatic t_zero();
        int hi, lo;
        word = 7'd5;
        wait_rise();
        chk("R6", "flag low before zero word", int'(illegal), 0);
        word = 7'd0;
        wait_rise();
        chk("R6", "flag at period end", int'(illegal), 1);
        measure(hi, lo);
        chk("R5", "zero word period", hi + lo, 3);
        chk("R5", "zero word low", lo, 2);
        word = 7'd5;
        wait_rise();
        measure(hi, lo);
        chk("R7", "legal period after zero", hi + lo, 7);
        chk("R7", "flag still set", int'(illegal), 1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7", "flag cleared by reset", int'(illegal), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset(7'd18);
        t_ratio("R2", 7'd18);
        t_ratio("R2", 7'd59);
        t_ratio("R2", 7'd2);
        t_ratio("R4", 7'd1);
        t_ratio("R4", 7'd127);
        t_change();
        t_zero();
        t_reset(7'd127);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule